// File: doc/BRIEF.md
# Per-Channel Selectable Debounce Filter

This block sits between a bank of external interrupt inputs and the interrupt controller. It re-times every input into the system clock domain. For the lowest `DB_CNT` channels it can also hold back a level change until the input has stayed at that new level for a chosen time. A shared prescaler divides the system clock into a slow tick, for example about 32 kHz. Each debounced channel compares a tick count against a target that a 3-bit time code selects. The supported durations run from half a millisecond to a quarter of a second. Debouncing is meant for level-sensitive channels.

Software configures the channels through three word-wide address windows: a view window for reads, a window where ones written set bits, and a window where ones written clear bits. Each 32-bit word holds the 8-bit control fields of four channels. Within a field there is an enable bit, a counter-restart bit that clears itself, and the time code. A full reconfiguration of a channel is a clear-window write of 0xFF to its byte, followed by a set-window write of the new code together with enable and restart.

Top module: `dbn_filter_bank`

## Requirements
- R1: Channels at or above `DB_CNT` are never filtered. Their output equals the input delayed by exactly two clocks. Their control bytes read as 0, and writes to those bytes have no effect.
- R2: A debounced channel whose enable bit is 0 drives the two-clock synchronized input straight to its output.
- R3: With enable set, the output takes a new input level only once that level has been stable for the number of ticks that the code selects: code 0 gives BASE_TICKS, code 1 gives 2×BASE_TICKS, and code k from 2 to 6 gives BASE_TICKS<<(k+3). With the default of 16 ticks at 32 kHz, this is 0.5, 1, 16, 32, 64, 128 and 256 ms.
- R4: If the input changes before the target count is reached, the count starts again and the output does not move. A pulse or a burst shorter than the target never reaches the output.
- R5: A write to the set window ORs the written ones into the enable and code bits. A write to the clear window clears them. A write to the view window is ignored. Reads of the set and clear windows return 0.
- R6: A 1 written to the restart bit through the set window zeroes that channel's tick count on the next clock. The output is left unchanged. The restart bit always reads back as 0.
- R7: Time code 7 gives the same duration as code 6.
- R8: Layout: the view, set and clear windows start at byte offsets 0x500, 0x600 and 0x700. Channel n uses byte lane n mod 4 of the word at window + 4×(n/4). In a byte, bit 0 is enable, bit 1 is restart and bits 6:4 are the code. Bits 2, 3 and 7 read as 0.
- R9: The tick is a one-clock pulse that occurs every PRESCALE system clocks.
- R10: After reset, every control field is 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_CH | Raw interrupt inputs |
| irq_out | output | NUM_CH | Synchronized and, where enabled, debounced outputs |
| bus_wr | input | 1 | Write strobe for the control windows |
| bus_addr | input | 12 | Byte address of the control access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The hardest case to reach is a restart that arrives in the middle of a count. The channel must already be part of the way toward its target, so the set-window restart write has to land after the input has been stable for several ticks but before the target is reached. The bench drives the input, waits half the target, and then issues the restart write. It then samples the output at a cycle after the moment the unrestarted count would have released the new level, and checks that the output still holds the old one. The bench also sweeps the longest codes. This shows that code 7 and code 6 expire on the same cycle window.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    localparam int unsigned FLD_EN_BIT   = 0;
    localparam int unsigned FLD_RST_BIT  = 1;
    localparam int unsigned FLD_CODE_LSB = 4;
    localparam int unsigned FLD_W        = 8;
    localparam int unsigned LANES        = 4;
    localparam int unsigned MAX_SHIFT    = 9;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_VIEW = 2'd1,
        WIN_SET  = 2'd2,
        WIN_CLR  = 2'd3
    } dbn_win_e;

    // Tick target for a 3-bit time code; code 7 saturates to code 6.
    function automatic int unsigned code_ticks(input logic [2:0] code,
                                               input int unsigned base);
        case (code)
            3'd0:    return base;
            3'd1:    return base * 2;
            3'd7:    return base << MAX_SHIFT;
            default: return base << (int'(code) + 3);
        endcase
    endfunction

endpackage

// File: rtl/dbn_tick_gen.sv
module dbn_tick_gen #(
    parameter int unsigned PRESCALE = 7812
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tick = (st_q.cnt == CW'(PRESCALE - 1));
        if (st_q.cnt == CW'(PRESCALE - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/dbn_ctrl_regs.sv
module dbn_ctrl_regs #(
    parameter int unsigned DB_CNT    = 16,
    parameter logic [11:0] VIEW_BASE = 12'h500,
    parameter logic [11:0] SET_BASE  = 12'h600,
    parameter logic [11:0] CLR_BASE  = 12'h700
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [11:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [DB_CNT-1:0]      en,
    output logic [DB_CNT-1:0][2:0] code,
    output logic [DB_CNT-1:0]      restart
);
    import dbn_pkg::*;

    localparam int unsigned NWORDS = (DB_CNT + LANES - 1) / LANES;

    typedef struct packed {
        logic [DB_CNT-1:0]      en;
        logic [DB_CNT-1:0][2:0] code;
        logic [DB_CNT-1:0]      rst;
    } rg_state_t;

    rg_state_t st_d, st_q;
    dbn_win_e  win;
    logic [5:0] widx;
    logic       unused_bits;

    assign widx        = bus_addr[7:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    always_comb begin
        if (bus_addr[11:8] == VIEW_BASE[11:8])      win = WIN_VIEW;
        else if (bus_addr[11:8] == SET_BASE[11:8])  win = WIN_SET;
        else if (bus_addr[11:8] == CLR_BASE[11:8])  win = WIN_CLR;
        else                                        win = WIN_NONE;
    end

    always_comb begin
        logic [7:0] fld;
        st_d     = st_q;
        st_d.rst = '0;
        fld      = '0;
        if (bus_wr && (widx < 6'(NWORDS))) begin
            for (int ch = 0; ch < int'(DB_CNT); ch++) begin
                if (widx == 6'(ch / LANES)) begin
                    fld = bus_wdata[FLD_W*(ch % LANES) +: FLD_W];
                    if (win == WIN_SET) begin
                        st_d.en[ch]   = st_q.en[ch] | fld[FLD_EN_BIT];
                        st_d.code[ch] = st_q.code[ch] | fld[FLD_CODE_LSB +: 3];
                        st_d.rst[ch]  = fld[FLD_RST_BIT];
                    end else if (win == WIN_CLR) begin
                        st_d.en[ch]   = st_q.en[ch] & ~fld[FLD_EN_BIT];
                        st_d.code[ch] = st_q.code[ch] & ~fld[FLD_CODE_LSB +: 3];
                    end
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if ((win == WIN_VIEW) && (widx < 6'(NWORDS))) begin
            for (int ch = 0; ch < int'(DB_CNT); ch++) begin
                if (widx == 6'(ch / LANES)) begin
                    bus_rdata[FLD_W*(ch % LANES) +: FLD_W] =
                        {1'b0, st_q.code[ch], 2'b00, 1'b0, st_q.en[ch]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en      = st_q.en;
    assign code    = st_q.code;
    assign restart = st_q.rst;

endmodule

// File: rtl/dbn_chan.sv
module dbn_chan #(
    parameter int unsigned BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sync_in,
    input  logic       en,
    input  logic [2:0] code,
    input  logic       restart,
    output logic       filt
);
    import dbn_pkg::*;

    localparam int unsigned MAX_TICKS = BASE_TICKS << MAX_SHIFT;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        logic             prev;
        logic             out;
        logic [CNT_W-1:0] cnt;
    } ch_state_t;

    ch_state_t      st_d, st_q;
    logic [CNT_W:0] cnt_inc;
    logic [CNT_W:0] target;

    assign cnt_inc = {1'b0, st_q.cnt} + 1'b1;
    assign target  = (CNT_W + 1)'(code_ticks(code, BASE_TICKS));

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
        if (!en) begin
            st_d.out = sync_in;
            st_d.cnt = '0;
        end else if (restart || (sync_in != st_q.prev) || (sync_in == st_q.out)) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (cnt_inc >= target) begin
                st_d.out = sync_in;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = en ? st_q.out : sync_in;

endmodule

// File: rtl/dbn_filter_bank.sv
module dbn_filter_bank #(
    parameter int unsigned NUM_CH     = 32,
    parameter int unsigned DB_CNT     = 16,
    parameter int unsigned PRESCALE   = 7812,
    parameter int unsigned BASE_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_in,
    output logic [NUM_CH-1:0] irq_out,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    typedef struct packed {
        logic [NUM_CH-1:0] s1;
        logic [NUM_CH-1:0] s2;
    } sy_state_t;

    sy_state_t sy_d, sy_q;
    logic                   tick;
    logic [DB_CNT-1:0]      ctl_en;
    logic [DB_CNT-1:0][2:0] ctl_code;
    logic [DB_CNT-1:0]      ctl_restart;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = irq_in;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    dbn_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    dbn_ctrl_regs #(.DB_CNT(DB_CNT)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .en       (ctl_en),
        .code     (ctl_code),
        .restart  (ctl_restart)
    );

    for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_ch
        if (ch < int'(DB_CNT)) begin : g_filt
            dbn_chan #(.BASE_TICKS(BASE_TICKS)) chan_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .sync_in(sy_q.s2[ch]),
                .en     (ctl_en[ch]),
                .code   (ctl_code[ch]),
                .restart(ctl_restart[ch]),
                .filt   (irq_out[ch])
            );
        end else begin : g_pass
            assign irq_out[ch] = sy_q.s2[ch];
        end
    end

endmodule

// File: rtl/dbn_filter_chk.sv
module dbn_filter_chk #(
    parameter int unsigned NUM_CH    = 32,
    parameter int unsigned DB_CNT    = 16,
    parameter int unsigned PRESCALE  = 7812,
    parameter logic [11:0] VIEW_BASE = 12'h500
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] irq_in,
    input logic [NUM_CH-1:0] irq_out,
    input logic              tick,
    input logic [DB_CNT-1:0] en_vec,
    input logic [11:0]       bus_addr,
    input logic [31:0]       bus_rdata
);
    localparam int unsigned GW = $clog2(PRESCALE + 1) + 1;

    logic [NUM_CH-1:0] pipe1, pipe2;
    logic [GW-1:0]     gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe1 <= '0;
            pipe2 <= '0;
            gap   <= '0;
        end else begin
            pipe1 <= irq_in;
            pipe2 <= pipe1;
            gap   <= tick ? GW'(1) : gap + 1'b1;
        end
    end

    for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_a
        if (ch < int'(DB_CNT)) begin : g_db
            // R2: disabled channel passes the synchronized input
            assert_disabled_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !en_vec[ch] |-> (irq_out[ch] == pipe2[ch]));
            // R3: enabled output only moves on the clock after a tick
            assert_change_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (en_vec[ch] && $past(en_vec[ch]) && (irq_out[ch] != $past(irq_out[ch])))
                |-> $past(tick));
        end else begin : g_by
            // R1: bypass channel is the input two clocks late
            assert_bypass_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
                irq_out[ch] == pipe2[ch]);
        end
    end

    // R6 and R8: restart and reserved bits read as zero in the view window
    assert_view_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[11:8] == VIEW_BASE[11:8]) |-> ((bus_rdata & 32'h8E8E8E8E) == 32'h0));

    // R9: tick period
    assert_tick_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap == GW'(PRESCALE)));
    assert_tick_gap_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GW'(PRESCALE));

endmodule

bind dbn_filter_bank dbn_filter_chk #(
    .NUM_CH  (NUM_CH),
    .DB_CNT  (DB_CNT),
    .PRESCALE(PRESCALE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .irq_out  (irq_out),
    .tick     (tick),
    .en_vec   (ctl_en),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/dbn_filter_bank_tb_top.sv
module dbn_filter_bank_tb_top;

    localparam int unsigned NCH  = 8;
    localparam int unsigned NDB  = 6;
    localparam int unsigned PS   = 2;
    localparam int unsigned BASE = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] irq_in = '0;
    logic [NCH-1:0] irq_out;
    logic           bus_wr = 1'b0;
    logic [11:0]    bus_addr = 12'h000;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;

    int checks   = 0;
    int failures = 0;
    bit wd_fired = 0;

    always #2 clk = ~clk;

    dbn_filter_bank #(
        .NUM_CH(NCH), .DB_CNT(NDB), .PRESCALE(PS), .BASE_TICKS(BASE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic int unsigned ticks_for(input int unsigned c);
        if (c == 0) return BASE;
        if (c == 1) return BASE * 2;
        if (c == 7) return BASE << 9;
        return BASE << (c + 3);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 12'h000;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 12'h000;
    endtask

    task automatic set_in(input int ch, input logic v);
        @(negedge clk);
        irq_in[ch] = v;
    endtask

    // Full reconfigure: clear the byte, then set code, enable and restart
    task automatic configure(input int ch, input logic [2:0] c);
        logic [11:0] off;
        int          sh;
        off = 12'(4 * (ch / 4));
        sh  = 8 * (ch % 4);
        bus_write(12'h700 + off, 32'hFF << sh);
        bus_write(12'h600 + off, {24'h0, 1'b0, c, 4'b0011} << sh);
        wait_cyc(3);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R10 outputs after reset", 32'(irq_out), 32'h0);
        bus_read(12'h500, d);
        check("R10 word0 after reset", d, 32'h0);
        bus_read(12'h504, d);
        check("R10 word1 after reset", d, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_write(12'h600, 32'h0000_0033);
        bus_read(12'h500, d);
        check("R5 set window ORs en and code", d, 32'h0000_0031);
        check("R6 restart bit reads zero", d & 32'h2, 32'h0);
        bus_write(12'h500, 32'hFFFF_FFFF);
        bus_read(12'h500, d);
        check("R5 view window write ignored", d, 32'h0000_0031);
        bus_read(12'h600, d);
        check("R5 set window reads zero", d, 32'h0);
        bus_write(12'h700, 32'h0000_0010);
        bus_read(12'h500, d);
        check("R5 clear window clears code bit", d, 32'h0000_0021);
        bus_write(12'h700, 32'h0000_00FF);
        bus_read(12'h500, d);
        check("R5 clear window full byte", d, 32'h0);
        bus_write(12'h604, 32'hFFFF_FFFF);
        bus_read(12'h504, d);
        check("R8 R1 lane layout and bypass bytes zero", d, 32'h0000_7171);
        bus_write(12'h704, 32'hFFFF_FFFF);
        bus_read(12'h504, d);
        check("R5 clear window whole word", d, 32'h0);
    endtask

    task automatic t_bypass;
        set_in(6, 1'b1);
        wait_cyc(1);
        check("R1 bypass not yet after one clock", 32'(irq_out[6]), 32'h0);
        wait_cyc(1);
        check("R1 bypass after two clocks", 32'(irq_out[6]), 32'h1);
        set_in(6, 1'b0);
        wait_cyc(2);
        check("R1 bypass falls after two clocks", 32'(irq_out[6]), 32'h0);
    endtask

    task automatic t_disabled;
        set_in(1, 1'b1);
        wait_cyc(1);
        check("R2 disabled not yet after one clock", 32'(irq_out[1]), 32'h0);
        wait_cyc(1);
        check("R2 disabled follows sync input", 32'(irq_out[1]), 32'h1);
    endtask

    task automatic t_delay(input int ch, input logic [2:0] c, input logic v, input string tag);
        int unsigned t;
        t = ticks_for(c);
        set_in(ch, v);
        wait_cyc(int'((t - 1) * PS + 2));
        check({tag, " still old before target"}, 32'(irq_out[ch]), 32'(!v));
        wait_cyc(int'(PS + 2));
        check({tag, " new level after target"}, 32'(irq_out[ch]), 32'(v));
    endtask

    task automatic t_glitch;
        set_in(2, 1'b1);
        wait_cyc(10);
        set_in(2, 1'b0);
        wait_cyc(40);
        check("R4 short pulse rejected", 32'(irq_out[2]), 32'h0);
        for (int i = 0; i < 6; i++) begin
            set_in(2, 1'(i % 2 == 0));
            wait_cyc(6);
            check("R4 burst never released", 32'(irq_out[2]), 32'h0);
        end
        set_in(2, 1'b0);
        wait_cyc(40);
        check("R4 output low after burst", 32'(irq_out[2]), 32'h0);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        configure(5, 3'd1);
        set_in(5, 1'b1);
        wait_cyc(8);
        bus_write(12'h604, 32'h0000_0200);
        wait_cyc(12);
        check("R6 restart delays release", 32'(irq_out[5]), 32'h0);
        wait_cyc(10);
        check("R6 release after restarted count", 32'(irq_out[5]), 32'h1);
        bus_read(12'h504, d);
        check("R6 restart bit self-cleared", d & 32'h0000_0200, 32'h0);
    endtask

    task automatic run_all;
        t_reset();
        t_regs();
        t_bypass();
        t_disabled();
        configure(2, 3'd1);
        t_delay(2, 3'd1, 1'b1, "R3 code1 rise");
        t_delay(2, 3'd1, 1'b0, "R3 code1 fall");
        configure(3, 3'd0);
        t_delay(3, 3'd0, 1'b1, "R3 code0 rise");
        configure(4, 3'd2);
        t_delay(4, 3'd2, 1'b1, "R3 code2 rise");
        t_glitch();
        t_restart();
        configure(3, 3'd7);
        t_delay(3, 3'd7, 1'b0, "R7 code7 equals code6");
        configure(4, 3'd6);
        t_delay(4, 3'd6, 1'b0, "R3 code6 fall");
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                wd_fired = 1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            checks++;
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule